// File: doc/BRIEF.md
# Three-Phase Switched Inverter Voltage Model

This block emulates the output stage of a two-level three-phase inverter inside a hardware-in-the-loop motor emulator. An external motor controller supplies three gate bits, one per phase. Each phase turns its gate bit into a bipolar switched voltage of plus or minus the DC-link voltage. It then smooths that voltage with a discrete first-order resistor-inductor model. Finally it multiplies the result by a compensation gain that undoes the amplitude loss of the smoothing stage. The three phase voltages feed the reference-frame transforms that sit downstream.

The DC-link voltage, the resistance coefficient, the Euler step coefficient (sample time over inductance) and the compensation gain are runtime inputs held by registers outside the block. The filter advances once per sample strobe. A valid pulse marks the cycle in which all three phase voltages carry the result of that step. All values are signed two's-complement Q16.16 words: 32 bits, with 16 fraction bits.

Top module: `invm_inverter_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three filter states, all three outputs and `out_valid` are cleared to zero.
- R2: A gate bit of 1 selects a switched voltage of +`vdc` for its phase, and a gate bit of 0 selects −`vdc` (saturating negation). Bit 0 of `pwm_in` drives phase a, bit 1 drives phase b and bit 2 drives phase c.
- R3: While `sample_en` is low, no filter state changes and no output changes, whatever `pwm_in`, `vdc` or the coefficients do.
- R4: On each edge with `sample_en` high, each phase state updates as i ← i + kL·(u − R·i). The inputs are taken at that edge.
- R5: Each phase output equals gain·(R·i), computed from the new state. Every product is the full product shifted right by 16 bits (rounding toward minus infinity) and then saturated.
- R6: `out_valid` is high exactly two clock edges after an edge at which `sample_en` was high, for one cycle per strobe. The outputs change only on the edge at which `out_valid` rises.
- R7: Any sum, difference or product that leaves the signed 32-bit range clamps to 0x7FFFFFFF or to 0x80000000. It never wraps.
- R8: The three phases use identical arithmetic and are independent. Each phase depends only on its own gate bit and its own state, plus the shared coefficients.
- R9: A new value of `vdc` or of any coefficient takes effect at the next strobe, with no other action needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Advances the filters by one step |
| pwm_in | input | 3 | Gate bits: bit 0 is phase a, bit 1 is b, bit 2 is c |
| vdc | input | 32 | DC-link voltage, Q16.16 |
| r_coef | input | 32 | Resistance coefficient R, Q16.16 |
| kl_coef | input | 32 | Euler step coefficient Ts/L, Q16.16 |
| gain_coef | input | 32 | Amplitude compensation gain 1/A, Q16.16 |
| va | output | 32 | Phase a voltage, Q16.16 |
| vb | output | 32 | Phase b voltage, Q16.16 |
| vc | output | 32 | Phase c voltage, Q16.16 |
| out_valid | output | 1 | One-cycle pulse: outputs hold a new step |

## Verification
The filter state is visible only through the outputs, and it is never corrected. A wrong state, for example one that wrapped instead of saturating, skipped a step or mixed up phases, shows up in the first valid output after the faulty step. It then stays in every later output of that phase until a reset. The bench therefore compares every valid pulse against a running model over hundreds of strobes. It also checks that nothing moves between strobes, since a stray update would appear as an output that differs from the model at the next pulse.

// File: rtl/invm_pkg.sv
// Package: shared Q16.16 type and saturating arithmetic helpers.
// Assumes two's-complement words; all helpers clamp instead of wrapping.
package invm_pkg;

    localparam int QW = 32;
    localparam int QF = 16;

    typedef logic signed [QW-1:0] q_t;

    localparam q_t Q_MAX = {1'b0, {(QW-1){1'b1}}};
    localparam q_t Q_MIN = {1'b1, {(QW-1){1'b0}}};

    // Saturating addition of two Q words.
    function automatic q_t q_add(input q_t a, input q_t b);
        logic signed [QW:0] s;
        s = {a[QW-1], a} + {b[QW-1], b};
        if (s[QW] != s[QW-1])
            return s[QW] ? Q_MIN : Q_MAX;
        return s[QW-1:0];
    endfunction

    // Saturating subtraction a - b.
    function automatic q_t q_sub(input q_t a, input q_t b);
        logic signed [QW:0] s;
        s = {a[QW-1], a} - {b[QW-1], b};
        if (s[QW] != s[QW-1])
            return s[QW] ? Q_MIN : Q_MAX;
        return s[QW-1:0];
    endfunction

    // Saturating fixed-point product, floor rounding.
    function automatic q_t q_mul(input q_t a, input q_t b);
        logic signed [2*QW-1:0] p;
        logic signed [2*QW-1:0] sh;
        logic signed [2*QW-1:0] hi;
        logic signed [2*QW-1:0] lo;
        p  = {{QW{a[QW-1]}}, a} * {{QW{b[QW-1]}}, b};
        sh = p >>> QF;
        hi = {{QW{1'b0}}, Q_MAX};
        lo = {{QW{1'b1}}, Q_MIN};
        if (sh > hi)
            return Q_MAX;
        if (sh < lo)
            return Q_MIN;
        return sh[QW-1:0];
    endfunction

endpackage

// File: rtl/invm_switch_map.sv
// Module: maps each gate bit to a bipolar switched voltage.
// Assumes a set bit means the upper switch conducts (+vdc), a clear bit
// means the lower one conducts (-vdc). Purely combinational.
module invm_switch_map
    import invm_pkg::*;
#(
    parameter int NUM_PH = 3
) (
    input  logic [NUM_PH-1:0] gate,
    input  q_t                vdc,
    output q_t                u_sw [NUM_PH]
);

    q_t vdc_neg;

    // Negated supply, shared by all legs.
    always_comb vdc_neg = q_sub('0, vdc);

    for (genvar k = 0; k < NUM_PH; k++) begin : g_leg
        // Select the switched level for this leg.
        always_comb u_sw[k] = gate[k] ? vdc : vdc_neg;
    end

endmodule

// File: rtl/invm_rl_stage.sv
// Module: one phase of the forward-Euler resistor-inductor state.
// Assumes kl = Ts/L and r = R are Q16.16; the state is the emulated current.
// The update runs only on step_en; reset is synchronous and active low.
module invm_rl_stage
    import invm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  q_t   u_sw,
    input  q_t   r_coef,
    input  q_t   kl_coef,
    output q_t   i_state
);

    q_t r_drop;
    q_t diff;
    q_t delta;
    q_t i_next;

    // Next state: i + kl*(u - r*i), every stage saturated.
    always_comb begin
        r_drop = q_mul(r_coef, i_state);
        diff   = q_sub(u_sw, r_drop);
        delta  = q_mul(kl_coef, diff);
        i_next = q_add(i_state, delta);
    end

    // State register, advanced once per step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            i_state <= '0;
        else if (step_en)
            i_state <= i_next;
    end

endmodule

// File: rtl/invm_out_scale.sv
// Module: turns a phase state into its compensated output voltage.
// Assumes gain is the precomputed reciprocal of the RL attenuation.
// The output register loads only on load_en, so it holds between steps.
module invm_out_scale
    import invm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  q_t   i_state,
    input  q_t   r_coef,
    input  q_t   gain_coef,
    output q_t   v_out
);

    q_t v_filt;
    q_t v_comp;

    // Filtered voltage r*i, then amplitude compensation.
    always_comb begin
        v_filt = q_mul(r_coef, i_state);
        v_comp = q_mul(gain_coef, v_filt);
    end

    // Output register, loaded one cycle after the state step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_out <= '0;
        else if (load_en)
            v_out <= v_comp;
    end

endmodule

// File: rtl/invm_inverter_top.sv
// Module: three-phase inverter voltage model, top level.
// Gate bits become +/-vdc, are smoothed by a forward-Euler RL model and
// rescaled by a compensation gain. Assumes runtime coefficients are held
// stable by the register block from a strobe until its valid pulse.
module invm_inverter_top
    import invm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic [2:0]           pwm_in,
    input  logic signed [31:0]   vdc,
    input  logic signed [31:0]   r_coef,
    input  logic signed [31:0]   kl_coef,
    input  logic signed [31:0]   gain_coef,
    output logic signed [31:0]   va,
    output logic signed [31:0]   vb,
    output logic signed [31:0]   vc,
    output logic                 out_valid
);

    localparam int NUM_PH = 3;

    q_t   u_sw    [NUM_PH];
    q_t   i_state [NUM_PH];
    q_t   v_out   [NUM_PH];
    logic load_q;

    invm_switch_map #(.NUM_PH(NUM_PH)) u_map (
        .gate (pwm_in),
        .vdc  (vdc),
        .u_sw (u_sw)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
        invm_rl_stage u_rl (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (sample_en),
            .u_sw    (u_sw[k]),
            .r_coef  (r_coef),
            .kl_coef (kl_coef),
            .i_state (i_state[k])
        );

        invm_out_scale u_scale (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_q),
            .i_state   (i_state[k]),
            .r_coef    (r_coef),
            .gain_coef (gain_coef),
            .v_out     (v_out[k])
        );
    end

    // Two-stage strobe pipeline: state step, then output load and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            load_q    <= sample_en;
            out_valid <= load_q;
        end
    end

    // Map the phase array onto the named outputs.
    always_comb begin
        va = v_out[0];
        vb = v_out[1];
        vc = v_out[2];
    end

endmodule

// File: rtl/invm_inverter_chk.sv
// Checker: timing and hold properties of the inverter model's ports.
module invm_inverter_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_en,
    input logic signed [31:0] va,
    input logic signed [31:0] vb,
    input logic signed [31:0] vc,
    input logic               out_valid
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && va == 0 && vb == 0 && vc == 0));

    assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> ##2 out_valid);

    assert_valid_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_en, 2));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(va) && $stable(vb) && $stable(vc)));

endmodule

bind invm_inverter_top invm_inverter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .va        (va),
    .vb        (vb),
    .vc        (vc),
    .out_valid (out_valid)
);

// File: tb/sim_invm_inverter_top.sv
module sim_invm_inverter_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_en;
    logic [2:0]  pwm_in;
    logic signed [31:0] vdc, r_coef, kl_coef, gain_coef;
    logic signed [31:0] va, vb, vc;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    longint m_i [3];

    always #5 clk = ~clk;

    invm_inverter_top u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pwm_in(pwm_in),
        .vdc(vdc), .r_coef(r_coef), .kl_coef(kl_coef), .gain_coef(gain_coef),
        .va(va), .vb(vb), .vc(vc), .out_valid(out_valid)
    );

    // Model arithmetic per R5/R7: clamp to signed 32 bits.
    function automatic longint m_sat(input longint x);
        if (x > 64'sd2147483647) return 64'sd2147483647;
        if (x < -64'sd2147483648) return -64'sd2147483648;
        return x;
    endfunction

    function automatic longint m_mul(input longint a, input longint b);
        longint p;
        p = a * b;
        return m_sat(p >>> 16);
    endfunction

    function automatic longint m_out(input int k);
        return m_mul(longint'(gain_coef), m_mul(longint'(r_coef), m_i[k]));
    endfunction

    // Model of R2/R4 for one strobe.
    task automatic m_step();
        for (int k = 0; k < 3; k++) begin
            longint u, d;
            u = pwm_in[k] ? longint'(vdc) : m_sat(-longint'(vdc));
            d = m_sat(u - m_mul(longint'(r_coef), m_i[k]));
            m_i[k] = m_sat(m_i[k] + m_mul(longint'(kl_coef), d));
        end
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe: drive, step model, check valid pulse and outputs.
    task automatic strobe(input logic [2:0] g, input string req);
        pwm_in = g;
        sample_en = 1'b1;
        m_step();
        @(negedge clk);
        sample_en = 1'b0;
        chk("R6 valid early", longint'(out_valid), 0);
        @(negedge clk);
        chk("R6 valid", longint'(out_valid), 1);
        chk({req, " va"}, longint'(va), m_out(0));
        chk({req, " vb"}, longint'(vb), m_out(1));
        chk({req, " vc"}, longint'(vc), m_out(2));
        @(negedge clk);
        chk("R6 valid width", longint'(out_valid), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) m_i[k] = 0;
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 va", longint'(va), 0);
        chk("R1 vb", longint'(vb), 0);
        chk("R1 vc", longint'(vc), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic signed [31:0] hold_a, hold_b, hold_c;
        void'($urandom(32'd1234));
        rst_n = 1'b0; sample_en = 1'b0; pwm_in = '0;
        vdc = 32'sh000A0000; r_coef = 32'sh00010000;
        kl_coef = 32'sh00004000; gain_coef = 32'sh00020000;
        @(negedge clk);
        do_reset();

        // R2 directed: 10 V, kL 0.25, R 1, gain 2 -> +/-5.0
        strobe(3'b101, "R2 R4 R5");
        chk("R2 va +vdc", longint'(va), 64'sh50000);
        chk("R2 vb -vdc", longint'(vb), -64'sh50000);
        chk("R8 vc matches va", longint'(vc), longint'(va));

        // R3: inputs move without a strobe, outputs hold
        hold_a = va; hold_b = vb; hold_c = vc;
        pwm_in = 3'b010; vdc = 32'sh00640000; kl_coef = 32'sh00010000;
        repeat (4) @(negedge clk);
        chk("R3 valid", longint'(out_valid), 0);
        chk("R3 va", longint'(va), longint'(hold_a));
        chk("R3 vb", longint'(vb), longint'(hold_b));
        chk("R3 vc", longint'(vc), longint'(hold_c));
        // R9: new coefficients apply at next strobe
        strobe(3'b010, "R9");

        // R7 saturation: step overflows and clamps
        do_reset();
        vdc = 32'sh40000000; kl_coef = 32'sh00020000;
        r_coef = 32'sh00010000; gain_coef = 32'sh00010000;
        strobe(3'b001, "R7");
        chk("R7 va clamp high", longint'(va), 64'sh7FFFFFFF);
        chk("R7 vb clamp low", longint'(vb), -64'sh80000000);
        strobe(3'b110, "R7 second step");

        // Random runs with realistic coefficients (R4 R5 R8 R9)
        do_reset();
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0) begin
                vdc       = 32'($urandom_range(0, 400)) <<< 16;
                r_coef    = 32'($urandom_range(0, 131072));
                kl_coef   = 32'($urandom_range(0, 32768));
                gain_coef = 32'($urandom_range(65536, 262144));
            end
            strobe(3'($urandom_range(0, 7)), "R4 R5 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule